// File: doc/BRIEF.md
# Serial Wire Debug Host Bring-Up Sequencer

This block is the host end of a two-wire debug link. It drives a debug clock and a shared, bidirectional data line, and on a single start pulse it runs a fixed bring-up script. The script moves the target from its four-wire scan mode into the two-wire protocol, resets the line, and then makes five protocol transactions. These read the debug-port identity word, request debug power-up, select the access-port register bank, and read the access-port identity word. That last read is posted, so a further read of the read-buffer register collects its value.

Every transaction is built from the same parts. The host sends an 8-bit request and hands the line to the target for one turnaround slot. It then samples a 3-bit acknowledge. A read is followed by 32 data bits and a parity bit from the target. A write is followed by a second turnaround, then by 32 data bits and a parity bit from the host. A short low idle run follows each transaction. When the script ends, `done` rises, `error` tells whether it failed, and the two captured identity words remain on the outputs until the next start.

Top module: `swd_link_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `swclk`, `idcode` and `apid` are all zero. While `busy` is high, `swclk` is low for HALF_DIV clock cycles and then high for HALF_DIV cycles, and each low-high pair is one bit slot. While `busy` is low, `swclk` stays low. `swdio_out` and `swdio_oe` change only at slot boundaries.
- R2: Asserting `start` while idle begins the script. The first 16 slots drive the constant 0xE79E with bit 0 first and `swdio_oe`=1.
- R3: Next come LRESET_BITS slots of 1 (at least 51), then IDLE_BITS slots of 0, all driven.
- R4: Each request takes 8 driven slots in this order: 1, APnDP, RnW, A[2], A[3], the XOR of those four bits, 0, 1.
- R5: One released slot (`swdio_oe`=0) follows each request. Then 3 acknowledge bits are sampled with `swdio_oe`=0 at the end of each slot, and the first bit received is ack[0]. 3'b001 means OK and 3'b010 means WAIT.
- R6: After an OK on a read, 32 data bits (bit 0 first) and a parity bit are sampled with the line released, and one released turnaround slot follows. If the parity bit differs from the XOR of the data, the script ends after that slot with `error`=1.
- R7: After an OK on a write, there is one released slot. Then 32 driven data bits (bit 0 first) and a driven bit equal to their XOR follow.
- R8: The transactions run in this order, given as (APnDP, RnW, A[3:2], write data): (0,1,00) identity read; (0,0,01, 0x5000_0000) power-up; (0,0,10, 0x0000_00F0) bank select; (1,1,11) access-port identity read; (0,1,11) read-buffer read.
- R9: Any acknowledge other than OK is followed by one released slot. A WAIT then repeats the same request, up to WAIT_LIMIT times per transaction. The next WAIT, or any other non-OK value, ends the script with `error`=1.
- R10: IDLE_BITS driven 0 slots follow each completed transaction. After the last transaction, `busy` falls and `done` and `error` (0) are set in the same cycle. `idcode` holds the first read's data and `apid` holds the read-buffer data. These values are held until the next start, and a new start clears `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up script when idle |
| swclk | output | 1 | Debug link clock |
| swdio_out | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when high |
| swdio_in | input | 1 | Data line as seen at the host |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished (held) |
| error | output | 1 | Script ended on a bad acknowledge or parity |
| idcode | output | 32 | Debug-port identity word |
| apid | output | 32 | Access-port identity word |

## Verification
The bench builds the block with HALF_DIV=2, LRESET_BITS=51 and IDLE_BITS=2. This keeps each slot four clocks long while the line reset stays at its shortest legal length, so a whole script fits in under 1,500 cycles and five scripts fit easily. WAIT_LIMIT=2 lets one run complete after two WAITs and another overrun the bound on its third WAIT. The target answers from precomputed slot lists, which also reach a fault acknowledge on the first request and a bad parity on the last read.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

  typedef enum logic [3:0] {
    PH_OFF, PH_SWITCH, PH_LRESET, PH_IDLE, PH_REQ, PH_TRN_REQ,
    PH_ACK, PH_TRN_W, PH_TX, PH_RX, PH_TRN_R, PH_TRN_F
  } phase_e;

  typedef struct packed {
    logic        ap;
    logic        rnw;
    logic [1:0]  a;      // {A3, A2}
    logic [31:0] wdata;
  } xfer_t;

  localparam int          NUM_XFER   = 5;
  localparam logic [15:0] SWITCH_SEQ = 16'hE79E;
  localparam logic [2:0]  ACK_OK     = 3'b001;
  localparam logic [2:0]  ACK_WAIT   = 3'b010;

  function automatic xfer_t script_step(input logic [2:0] i);
    case (i)
      3'd0:    return {1'b0, 1'b1, 2'b00, 32'h0000_0000};
      3'd1:    return {1'b0, 1'b0, 2'b01, 32'h5000_0000};
      3'd2:    return {1'b0, 1'b0, 2'b10, 32'h0000_00F0};
      3'd3:    return {1'b1, 1'b1, 2'b11, 32'h0000_0000};
      3'd4:    return {1'b0, 1'b1, 2'b11, 32'h0000_0000};
      default: return '0;
    endcase
  endfunction

  // bit 0 is sent first
  function automatic logic [7:0] req_bits(input xfer_t x);
    logic p;
    p = x.ap ^ x.rnw ^ x.a[0] ^ x.a[1];
    return {1'b1, 1'b0, p, x.a[1], x.a[0], x.rnw, x.ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic slot_end
);
  localparam int SLOT = 2 * HALF_DIV;
  localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)                         cnt_d = '0;
    else if (cnt_q == CW'(SLOT - 1))  cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign swclk    = run && (cnt_q >= CW'(HALF_DIV));
  assign slot_end = run && (cnt_q == CW'(SLOT - 1));

  // R1: a new slot always opens with the clock low
  p_slot_opens_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_end) && run |-> !swclk);
  // R1: the clock falls only at the end of a slot or when the run stops
  p_fall_at_slot_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swclk) |-> ($past(slot_end) || !run));

endmodule

// File: rtl/swd_rx_shift.sv
module swd_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {din, word_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R6: the word moves only on a sampled bit
  p_word_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(word_q));

endmodule

// File: rtl/swd_link_seq.sv
module swd_link_seq
  import swd_seq_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int LRESET_BITS = 51,
  parameter int IDLE_BITS   = 2,
  parameter int WAIT_LIMIT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        swclk,
  output logic        swdio_out,
  output logic        swdio_oe,
  input  logic        swdio_in,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] idcode,
  output logic [31:0] apid
);
  localparam int M1    = (LRESET_BITS > 33) ? LRESET_BITS : 33;
  localparam int M2    = (IDLE_BITS > M1) ? IDLE_BITS : M1;
  localparam int IDX_W = $clog2(M2 + 1);
  localparam int WW    = $clog2(WAIT_LIMIT + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [2:0]       xfer_q, xfer_d;
  logic [WW-1:0]    wait_q, wait_d;
  logic [2:0]       ack_q, ack_d;
  logic             err_q, err_d;
  logic             busy_q, busy_d, done_q, done_d, error_q, error_d;
  logic [31:0]      idcode_q, idcode_d, apid_q, apid_d;

  logic        slot_end;
  logic [31:0] rx_word;
  logic        rx_shift;
  xfer_t       cur;
  logic [7:0]  req;
  logic [2:0]  ack_full;
  logic        par_ok;

  swd_clk_div #(.HALF_DIV(HALF_DIV)) i_div (
    .clk(clk), .rst_n(rst_s), .run(busy_q), .swclk(swclk), .slot_end(slot_end)
  );

  assign rx_shift = slot_end && (phase_q == PH_RX) && (idx_q < IDX_W'(32));

  swd_rx_shift #(.W(32)) i_rx (
    .clk(clk), .rst_n(rst_s), .shift_en(rx_shift), .din(swdio_in), .word(rx_word)
  );

  assign cur      = script_step(xfer_q);
  assign req      = req_bits(cur);
  assign ack_full = {swdio_in, ack_q[2:1]};
  assign par_ok   = ((^rx_word) == swdio_in);

  // next state
  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    xfer_d   = xfer_q;
    wait_d   = wait_q;
    ack_d    = ack_q;
    err_d    = err_q;
    busy_d   = busy_q;
    done_d   = done_q;
    error_d  = error_q;
    idcode_d = idcode_q;
    apid_d   = apid_q;

    if (phase_q == PH_OFF) begin
      if (start) begin
        phase_d = PH_SWITCH;
        idx_d   = '0;
        xfer_d  = '0;
        wait_d  = '0;
        err_d   = 1'b0;
        busy_d  = 1'b1;
        done_d  = 1'b0;
        error_d = 1'b0;
      end
    end else if (slot_end) begin
      idx_d = idx_q + 1'b1;
      case (phase_q)
        PH_SWITCH: if (idx_q == IDX_W'(15)) begin
          phase_d = PH_LRESET; idx_d = '0;
        end
        PH_LRESET: if (idx_q == IDX_W'(LRESET_BITS - 1)) begin
          phase_d = PH_IDLE; idx_d = '0;
        end
        PH_IDLE: if (idx_q == IDX_W'(IDLE_BITS - 1)) begin
          idx_d = '0;
          if (xfer_q == 3'(NUM_XFER)) begin
            phase_d = PH_OFF; busy_d = 1'b0; done_d = 1'b1; error_d = 1'b0;
          end else begin
            phase_d = PH_REQ;
          end
        end
        PH_REQ: if (idx_q == IDX_W'(7)) begin
          phase_d = PH_TRN_REQ; idx_d = '0;
        end
        PH_TRN_REQ: begin
          phase_d = PH_ACK; idx_d = '0;
        end
        PH_ACK: begin
          ack_d = ack_full;
          if (idx_q == IDX_W'(2)) begin
            idx_d = '0;
            if (ack_full == ACK_OK) begin
              wait_d  = '0;
              phase_d = cur.rnw ? PH_RX : PH_TRN_W;
            end else if ((ack_full == ACK_WAIT) && (wait_q < WW'(WAIT_LIMIT))) begin
              wait_d  = wait_q + 1'b1;
              phase_d = PH_TRN_F;
            end else begin
              err_d   = 1'b1;
              phase_d = PH_TRN_F;
            end
          end
        end
        PH_TRN_W: begin
          phase_d = PH_TX; idx_d = '0;
        end
        PH_TX: if (idx_q == IDX_W'(32)) begin
          phase_d = PH_IDLE; idx_d = '0; xfer_d = xfer_q + 1'b1;
        end
        PH_RX: if (idx_q == IDX_W'(32)) begin
          phase_d = PH_TRN_R; idx_d = '0;
          if (!par_ok)                 err_d    = 1'b1;
          else if (xfer_q == 3'd0)     idcode_d = rx_word;
          else if (xfer_q == 3'd4)     apid_d   = rx_word;
        end
        PH_TRN_R: begin
          idx_d = '0;
          if (err_q) begin
            phase_d = PH_OFF; busy_d = 1'b0; done_d = 1'b1; error_d = 1'b1;
          end else begin
            phase_d = PH_IDLE; xfer_d = xfer_q + 1'b1;
          end
        end
        PH_TRN_F: begin
          idx_d = '0;
          if (err_q) begin
            phase_d = PH_OFF; busy_d = 1'b0; done_d = 1'b1; error_d = 1'b1;
          end else begin
            phase_d = PH_REQ;
          end
        end
        default: begin
          phase_d = PH_OFF; busy_d = 1'b0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase_q  <= PH_OFF;
      idx_q    <= '0;
      xfer_q   <= '0;
      wait_q   <= '0;
      ack_q    <= '0;
      err_q    <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      error_q  <= 1'b0;
      idcode_q <= '0;
      apid_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      xfer_q   <= xfer_d;
      wait_q   <= wait_d;
      ack_q    <= ack_d;
      err_q    <= err_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
      error_q  <= error_d;
      idcode_q <= idcode_d;
      apid_q   <= apid_d;
    end
  end

  // line drive
  always_comb begin
    swdio_oe  = 1'b0;
    swdio_out = 1'b0;
    case (phase_q)
      PH_SWITCH: begin swdio_oe = 1'b1; swdio_out = SWITCH_SEQ[idx_q[3:0]]; end
      PH_LRESET: begin swdio_oe = 1'b1; swdio_out = 1'b1; end
      PH_IDLE:   begin swdio_oe = 1'b1; swdio_out = 1'b0; end
      PH_REQ:    begin swdio_oe = 1'b1; swdio_out = req[idx_q[2:0]]; end
      PH_TX: begin
        swdio_oe  = 1'b1;
        swdio_out = (idx_q == IDX_W'(32)) ? (^cur.wdata) : cur.wdata[idx_q[4:0]];
      end
      default: ;
    endcase
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign error  = error_q;
  assign idcode = idcode_q;
  assign apid   = apid_q;

  // R1: host line values change only at slot boundaries
  p_drive_stable_r1: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q && $past(busy_q) && !$past(slot_end) |-> $stable(swdio_out) && $stable(swdio_oe));
  // R1: clock parked low when idle
  p_clk_parked_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !swclk);
  // R5: line released while the acknowledge is sampled
  p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (phase_q == PH_ACK) |-> !swdio_oe);
  // R9: retry count never exceeds its bound
  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_s)
    wait_q <= WW'(WAIT_LIMIT));
  // R10: completion only at the end of a running script
  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> $past(busy) && !busy);
  // R10: error is reported only together with done
  p_error_with_done_r10: assert property (@(posedge clk) disable iff (!rst_s)
    error |-> done);

endmodule

// File: tb/test_swd_link_seq.sv
`timescale 1ns/1ps
module test_swd_link_seq;
  localparam int HALF = 2;
  localparam int LRB  = 51;
  localparam int IDB  = 2;
  localparam int WLIM = 2;

  logic clk, rst_n, start, swdio_in;
  logic swclk, swdio_out, swdio_oe, busy, done, error;
  logic [31:0] idcode, apid;

  swd_link_seq #(.HALF_DIV(HALF), .LRESET_BITS(LRB), .IDLE_BITS(IDB), .WAIT_LIMIT(WLIM))
  i_swd_link_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in), .busy(busy), .done(done), .error(error),
    .idcode(idcode), .apid(apid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected slot list: host enable, host value, target value, requirement tag
  bit    q_oe[$];
  bit    q_val[$];
  bit    q_tgt[$];
  string q_tag[$];

  task automatic push(input bit oe, input bit v, input bit t, input string tag);
    q_oe.push_back(oe); q_val.push_back(v); q_tgt.push_back(t); q_tag.push_back(tag);
  endtask

  // slot consumer: target model and bit-level reference
  always @(posedge swclk) begin
    if (q_oe.size() == 0) begin
      check(1'b0, "R10 unexpected slot", 32'd1, 32'd0);
    end else begin
      bit e_oe, e_val, e_tgt;
      string e_tag;
      e_oe = q_oe.pop_front(); e_val = q_val.pop_front();
      e_tgt = q_tgt.pop_front(); e_tag = q_tag.pop_front();
      check(swdio_oe == e_oe, {e_tag, " oe"}, 32'(swdio_oe), 32'(e_oe));
      if (e_oe) check(swdio_out == e_val, {e_tag, " bit"}, 32'(swdio_out), 32'(e_val));
      swdio_in <= e_tgt;
    end
  end

  // per-clock clock-shape reference (R1)
  int ph = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        check(swclk == (ph >= HALF), "R1 swclk phase", 32'(swclk), 32'(ph >= HALF));
        ph = (ph + 1) % (2 * HALF);
      end else begin
        check(!swclk, "R1 swclk idle", 32'(swclk), 32'd0);
        ph = 0;
      end
    end
  end

  task automatic push_preamble();
    for (int i = 0; i < 16; i++) push(1'b1, (16'hE79E >> i) & 1, 1'b1, "R2 switch");
    for (int i = 0; i < LRB; i++) push(1'b1, 1'b1, 1'b1, "R3 line reset");
    for (int i = 0; i < IDB; i++) push(1'b1, 1'b0, 1'b1, "R3 idle");
  endtask

  // returns 1 when the script ends inside this transaction
  task automatic push_xfer(input int i, input int wait_x, input int n_wait, input int fault_x,
                           input int bad_x, input logic [31:0] idv, input logic [31:0] apv,
                           output bit ended);
    bit ap, rnw;
    logic [1:0] a;
    logic [31:0] wd, rd;
    logic [2:0] ack;
    bit [7:0] rq;
    int k;
    // R8 script table
    case (i)
      0: begin ap = 0; rnw = 1; a = 2'b00; wd = 0; end
      1: begin ap = 0; rnw = 0; a = 2'b01; wd = 32'h5000_0000; end
      2: begin ap = 0; rnw = 0; a = 2'b10; wd = 32'h0000_00F0; end
      3: begin ap = 1; rnw = 1; a = 2'b11; wd = 0; end
      default: begin ap = 0; rnw = 1; a = 2'b11; wd = 0; end
    endcase
    rd = (i == 0) ? idv : (i == 3) ? 32'h1357_9BDF : apv;
    rq = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
    ended = 0;
    k = 0;
    forever begin
      for (int b = 0; b < 8; b++) push(1'b1, rq[b], 1'b1, "R4 request");
      push(1'b0, 1'b0, 1'b1, "R5 turnaround");
      ack = (i == wait_x && k < n_wait) ? 3'b010 : (i == fault_x) ? 3'b100 : 3'b001;
      for (int b = 0; b < 3; b++) push(1'b0, 1'b0, ack[b], "R5 ack");
      if (ack == 3'b001) begin
        if (rnw) begin
          for (int b = 0; b < 32; b++) push(1'b0, 1'b0, rd[b], "R6 read data");
          push(1'b0, 1'b0, (^rd) ^ (i == bad_x), "R6 read parity");
          push(1'b0, 1'b0, 1'b1, "R6 turnaround");
          if (i == bad_x) begin ended = 1; return; end
        end else begin
          push(1'b0, 1'b0, 1'b1, "R7 turnaround");
          for (int b = 0; b < 32; b++) push(1'b1, wd[b], 1'b1, "R7 write data");
          push(1'b1, ^wd, 1'b1, "R7 write parity");
        end
        for (int b = 0; b < IDB; b++) push(1'b1, 1'b0, 1'b1, "R10 idle");
        return;
      end
      push(1'b0, 1'b0, 1'b1, "R9 turnaround");
      if (ack == 3'b010 && k < WLIM) k++;
      else begin ended = 1; return; end
    end
  endtask

  task automatic scenario(input string name, input int wait_x, input int n_wait, input int fault_x,
                          input int bad_x, input logic [31:0] idv, input logic [31:0] apv,
                          input bit exp_err);
    bit ended;
    q_oe.delete(); q_val.delete(); q_tgt.delete(); q_tag.delete();
    push_preamble();
    for (int i = 0; i < 5; i++) begin
      push_xfer(i, wait_x, n_wait, fault_x, bad_x, idv, apv, ended);
      if (ended) break;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, {name, " R2 start accepted"}, 32'(busy), 32'd1);
    while (!done) @(negedge clk);
    check(!busy, {name, " R10 busy low at done"}, 32'(busy), 32'd0);
    check(error == exp_err, {name, exp_err ? " R9 error flag" : " R10 error flag"},
          32'(error), 32'(exp_err));
    check(q_oe.size() == 0, {name, " R10 slots left"}, 32'(q_oe.size()), 32'd0);
    if (!exp_err) begin
      check(idcode == idv, {name, " R10 idcode"}, idcode, idv);
      check(apid == apv, {name, " R10 apid"}, apid, apv);
    end
    repeat (8) @(negedge clk);
    check(done && !busy, {name, " R10 done held"}, 32'(done), 32'd1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; swdio_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !swclk, "R1 reset flags", {busy, done, error, swclk}, 0);
    check(idcode == 0 && apid == 0, "R1 reset words", idcode | apid, 0);
    // R8 full script, R9 two waits then OK on the power-up write
    scenario("s1", 1, 2, -1, -1, 32'h2BA0_1477, 32'h0477_0021, 1'b0);
    // R9 fault acknowledge on the first request
    scenario("s2", -1, 0, 0, -1, 32'h1111_2222, 32'h3333_4444, 1'b1);
    // R6 bad parity on the read-buffer read
    scenario("s3", -1, 0, -1, 4, 32'h5555_6666, 32'h7777_8888, 1'b1);
    // R9 wait bound exceeded on the bank select
    scenario("s4", 2, 3, -1, -1, 32'h0BAD_F00D, 32'h0000_0001, 1'b1);
    // R10 clean rerun updates the captured words
    scenario("s5", -1, 0, -1, -1, 32'h6BA0_2477, 32'h2477_0011, 1'b0);
    finish_run();
  end

endmodule